// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block keeps the issue state of the warps resident on one multiprocessor, up to 24 by default, which is 768 threads at 32 threads per warp. Each warp offers one buffered instruction. That instruction has a valid flag, two source register indices, one destination register index with a write-enable, and a latency-class tag. For each warp the block keeps one pending-write bit per architectural register. A warp is eligible when none of the registers its buffered instruction touches has a write outstanding.

When the dispatch lanes are free, the block picks one eligible warp in round-robin order and registers that warp's instruction on the issue outputs. If the instruction writes a register, the block marks that register pending. The lanes then stay occupied for `ISSUE_CYCLES` cycles in total, because the 32 threads are fed over 8 lanes. Completion events arrive as tagged writebacks (warp, register) and clear pending bits. A writeback is visible to the eligibility check in the same cycle it arrives. Fetch, decode and the execution units sit outside the block. The environment consumes an entry once it has been issued and may refill it.

Top module: `warp_issue_sched`

## Requirements
- R1: After a synchronous active-low reset, `issue_valid` and `dispatch_busy` are 0 and no register of any warp is pending.
- R2: A warp can be issued only if its entry is valid, neither source register is pending, and, when the entry writes a register (`ibuf_wen`=1), its destination register is not pending either.
- R3: Issuing an instruction with `ibuf_wen`=1 marks its destination register pending for that warp. Later instructions of that warp that use this register stall.
- R4: A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears that warp's pending bit. The clearing is seen by the eligibility check of the same cycle, so the warp can issue in that cycle. A `wb_warp` at or above `NUM_WARPS` has no effect.
- R5: At most one instruction issues per selection. `issue_valid` is a one-cycle pulse registered at the selecting clock edge. After an issue, `dispatch_busy` is 1 for `ISSUE_CYCLES-1` cycles and no selection takes place. Issues are therefore at least `ISSUE_CYCLES` cycles apart.
- R6: The search for an eligible warp starts at the warp numbered one above the last issued warp, wrapping from `NUM_WARPS-1` to 0. After reset it starts at warp 0.
- R7: A stalled warp never blocks issue. While any warp is eligible and the lanes are free, some warp issues.
- R8: The issue outputs (`issue_warp`, `issue_dst`, `issue_src_a`, `issue_src_b`, `issue_wen`, `issue_lat`) carry the chosen warp's number and its buffer entry as sampled at the selecting edge.
- R9: If an issue writes a register and a writeback for the same warp and register arrives in the same cycle, the register ends up pending.
- R10: An instruction whose destination register is still pending (write after write) stalls until that register is written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ibuf_valid | input | NUM_WARPS | Per-warp buffered instruction present |
| ibuf_wen | input | NUM_WARPS | Per-warp instruction writes its destination |
| ibuf_dst | input | NUM_WARPS*RIDX_W | Per-warp destination register index |
| ibuf_src_a | input | NUM_WARPS*RIDX_W | Per-warp first source register index |
| ibuf_src_b | input | NUM_WARPS*RIDX_W | Per-warp second source register index |
| ibuf_lat | input | NUM_WARPS*2 | Per-warp latency class tag |
| wb_valid | input | 1 | Writeback event present |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | RIDX_W | Register of the writeback |
| issue_valid | output | 1 | One-cycle issue pulse |
| issue_warp | output | WID_W | Issued warp number |
| issue_wen | output | 1 | Issued instruction writes a register |
| issue_dst | output | RIDX_W | Issued destination register |
| issue_src_a | output | RIDX_W | Issued first source register |
| issue_src_b | output | RIDX_W | Issued second source register |
| issue_lat | output | 2 | Issued latency class |
| dispatch_busy | output | 1 | Lanes still occupied by the last issue |

## Verification
The bench builds the block with 6 warps, 8 registers per warp and an issue occupancy of 4 cycles. With only 6 warps the round-robin pointer wraps every few issues. With only 8 registers, random traffic often hits source, destination and write-after-write conflicts. Directed sequences cover same-cycle writeback bypass, an issue and a writeback racing on the same register, and a stalled warp sitting beside a ready one. A long random run is then compared, on every clock, against a behavioural model of the scoreboard, the pointer and the occupancy counter.

// File: rtl/wsched_pkg.sv
// Shared definitions for the warp issue scheduler.
// Assumes: latency class is an opaque 2-bit tag carried through to issue.
package wsched_pkg;
    localparam int LAT_W = 2;

    typedef enum logic [LAT_W-1:0] {
        LAT_ALU  = 2'd0,
        LAT_SFU  = 2'd1,
        LAT_MEM  = 2'd2,
        LAT_TEX  = 2'd3
    } lat_class_e;
endpackage

// File: rtl/warp_scoreboard.sv
// Per-warp pending-write scoreboard and eligibility evaluation.
// Holds one pending bit per register per warp. A writeback clear is applied
// before the eligibility check (bypass). A set from an issue wins over a clear
// of the same bit in the same cycle.
// Assumes: NUM_REGS is a power of two; wb_warp values >= NUM_WARPS are ignored.
module warp_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          ibuf_valid,
    input  logic [NUM_WARPS-1:0]          ibuf_wen,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_dst,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_src_a,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_src_b,
    input  logic                          wb_valid,
    input  logic [WID_W-1:0]              wb_warp,
    input  logic [RIDX_W-1:0]             wb_reg,
    input  logic                          set_valid,
    input  logic [WID_W-1:0]              set_warp,
    input  logic [RIDX_W-1:0]             set_reg,
    output logic [NUM_WARPS-1:0]          eligible
);
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_q;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] clr_mask;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] set_mask;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_eff;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [RIDX_W-1:0] sa, sb, dd;
        assign sa = ibuf_src_a[w*RIDX_W +: RIDX_W];
        assign sb = ibuf_src_b[w*RIDX_W +: RIDX_W];
        assign dd = ibuf_dst[w*RIDX_W +: RIDX_W];

        // Build the one-hot clear and set masks for this warp.
        always_comb begin
            clr_mask[w] = '0;
            set_mask[w] = '0;
            if (wb_valid && (wb_warp == WID_W'(w)))
                clr_mask[w][wb_reg] = 1'b1;
            if (set_valid && (set_warp == WID_W'(w)))
                set_mask[w][set_reg] = 1'b1;
        end

        // Pending view after same-cycle writeback bypass.
        assign pend_eff[w] = pend_q[w] & ~clr_mask[w];

        // Eligibility: valid entry with no operand awaiting a write.
        assign eligible[w] = ibuf_valid[w]
                           & ~pend_eff[w][sa]
                           & ~pend_eff[w][sb]
                           & ~(ibuf_wen[w] & pend_eff[w][dd]);
    end

    // Scoreboard state update: clear on writeback, set on issue (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_eff | set_mask;
    end

    a_r3_set_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> pend_q[$past(set_warp)][$past(set_reg)]);

    a_r4_wb_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (int'(wb_warp) < NUM_WARPS) &&
         !(set_valid && set_warp == wb_warp && set_reg == wb_reg))
        |=> !pend_q[$past(wb_warp)][$past(wb_reg)]);

    a_r10_set_only_free_reg: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> !pend_eff[set_warp][set_reg]);
endmodule

// File: rtl/rr_pick.sv
// Round-robin picker: returns the first requester at or after ptr, wrapping.
// Assumes: ptr < N. Purely combinational; clk/rst_n feed only the checks.
module rr_pick #(
    parameter int N     = 24,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    // Scan N positions starting at ptr and take the first request found.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(ptr) + i;
            if (j >= N) j = j - N;
            if (!gnt_valid && req[j]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(j);
            end
        end
    end

    a_r7_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);

    a_r7_no_idle_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_valid);
endmodule

// File: rtl/issue_pacer.sv
// Lane occupancy counter: after each issue the lanes stay busy so that the
// next issue comes ISSUE_CYCLES cycles later at the earliest.
// Assumes: fire is raised only while ready is high.
module issue_pacer #(
    parameter int ISSUE_CYCLES = 4,
    localparam int CNT_W       = $clog2(ISSUE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ready,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load occupancy on issue, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (fire)        cnt_q <= CNT_W'(ISSUE_CYCLES - 1);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);
    assign busy  = ~ready;

    a_r5_no_fire_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fire);
endmodule

// File: rtl/warp_issue_sched.sv
// Scoreboarded multithreaded warp issue scheduler (top).
// Each cycle with free lanes, picks one eligible warp round-robin starting
// after the last issued warp, registers its instruction on the issue port,
// marks its destination pending and occupies the lanes for ISSUE_CYCLES.
// Assumes: the environment consumes an issued entry before the lanes free up.
module warp_issue_sched
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS    = 24,
    parameter int NUM_REGS     = 16,
    parameter int ISSUE_CYCLES = 4,
    localparam int WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RIDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          ibuf_valid,
    input  logic [NUM_WARPS-1:0]          ibuf_wen,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_dst,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_src_a,
    input  logic [NUM_WARPS*RIDX_W-1:0]   ibuf_src_b,
    input  logic [NUM_WARPS*LAT_W-1:0]    ibuf_lat,
    input  logic                          wb_valid,
    input  logic [WID_W-1:0]              wb_warp,
    input  logic [RIDX_W-1:0]             wb_reg,
    output logic                          issue_valid,
    output logic [WID_W-1:0]              issue_warp,
    output logic                          issue_wen,
    output logic [RIDX_W-1:0]             issue_dst,
    output logic [RIDX_W-1:0]             issue_src_a,
    output logic [RIDX_W-1:0]             issue_src_b,
    output logic [LAT_W-1:0]              issue_lat,
    output logic                          dispatch_busy
);
    logic [NUM_WARPS-1:0] eligible;
    logic [NUM_WARPS-1:0] req;
    logic                 lanes_ready;
    logic                 pick_valid;
    logic [WID_W-1:0]     pick_idx;
    logic                 fire;
    logic [WID_W-1:0]     rr_ptr;
    logic                 set_valid;
    logic [RIDX_W-1:0]    pick_dst;

    assign pick_dst  = ibuf_dst[pick_idx*RIDX_W +: RIDX_W];
    assign set_valid = fire & ibuf_wen[pick_idx];

    warp_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ibuf_valid (ibuf_valid),
        .ibuf_wen   (ibuf_wen),
        .ibuf_dst   (ibuf_dst),
        .ibuf_src_a (ibuf_src_a),
        .ibuf_src_b (ibuf_src_b),
        .wb_valid   (wb_valid),
        .wb_warp    (wb_warp),
        .wb_reg     (wb_reg),
        .set_valid  (set_valid),
        .set_warp   (pick_idx),
        .set_reg    (pick_dst),
        .eligible   (eligible)
    );

    // Only offer requests to the picker when the lanes can take an issue.
    assign req = lanes_ready ? eligible : '0;

    rr_pick #(.N(NUM_WARPS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .ptr       (rr_ptr),
        .gnt_valid (pick_valid),
        .gnt_idx   (pick_idx)
    );

    assign fire = pick_valid;

    issue_pacer #(.ISSUE_CYCLES(ISSUE_CYCLES)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .ready (lanes_ready),
        .busy  (dispatch_busy)
    );

    // Round-robin pointer: move to the warp after the one just issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (fire)
            rr_ptr <= (int'(pick_idx) == NUM_WARPS - 1) ? '0 : pick_idx + 1'b1;
    end

    // Issue register: capture the chosen warp's buffered instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_wen   <= 1'b0;
            issue_dst   <= '0;
            issue_src_a <= '0;
            issue_src_b <= '0;
            issue_lat   <= '0;
        end else begin
            issue_valid <= fire;
            if (fire) begin
                issue_warp  <= pick_idx;
                issue_wen   <= ibuf_wen[pick_idx];
                issue_dst   <= pick_dst;
                issue_src_a <= ibuf_src_a[pick_idx*RIDX_W +: RIDX_W];
                issue_src_b <= ibuf_src_b[pick_idx*RIDX_W +: RIDX_W];
                issue_lat   <= ibuf_lat[pick_idx*LAT_W +: LAT_W];
            end
        end
    end

    a_r2_issued_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> eligible[pick_idx]);

    a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    if (ISSUE_CYCLES > 1) begin : g_busy_chk
        a_r5_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid |-> dispatch_busy);
    end
endmodule

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
    localparam int NW  = 6;
    localparam int NR  = 8;
    localparam int IC  = 4;
    localparam int WW  = $clog2(NW);
    localparam int RW  = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Bench-side buffer entries
    logic          e_valid [NW];
    logic          e_wen   [NW];
    logic [RW-1:0] e_dst   [NW];
    logic [RW-1:0] e_sa    [NW];
    logic [RW-1:0] e_sb    [NW];
    logic [1:0]    e_lat   [NW];

    logic [NW-1:0]    ibuf_valid, ibuf_wen;
    logic [NW*RW-1:0] ibuf_dst, ibuf_src_a, ibuf_src_b;
    logic [NW*2-1:0]  ibuf_lat;
    logic             wb_valid;
    logic [WW-1:0]    wb_warp;
    logic [RW-1:0]    wb_reg;

    logic          issue_valid, issue_wen, dispatch_busy;
    logic [WW-1:0] issue_warp;
    logic [RW-1:0] issue_dst, issue_src_a, issue_src_b;
    logic [1:0]    issue_lat;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            ibuf_valid[w]          = e_valid[w];
            ibuf_wen[w]            = e_wen[w];
            ibuf_dst[w*RW +: RW]   = e_dst[w];
            ibuf_src_a[w*RW +: RW] = e_sa[w];
            ibuf_src_b[w*RW +: RW] = e_sb[w];
            ibuf_lat[w*2 +: 2]     = e_lat[w];
        end
    end

    warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .ISSUE_CYCLES(IC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ibuf_valid(ibuf_valid), .ibuf_wen(ibuf_wen), .ibuf_dst(ibuf_dst),
        .ibuf_src_a(ibuf_src_a), .ibuf_src_b(ibuf_src_b), .ibuf_lat(ibuf_lat),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_wen(issue_wen),
        .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
        .issue_lat(issue_lat), .dispatch_busy(dispatch_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit model_on = 0;

    // Behavioural reference model
    bit m_pend [NW][NR];
    int m_ptr, m_cnt;
    bit x_iv;
    int x_warp, x_dst, x_sa, x_sb, x_lat;
    bit x_wen;

    function automatic bit m_ok(int w);
        if (!e_valid[w]) return 0;
        if (m_pend[w][e_sa[w]] || m_pend[w][e_sb[w]]) return 0;
        if (e_wen[w] && m_pend[w][e_dst[w]]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pend[a, b]) m_pend[a][b] = 0;
            m_ptr = 0; m_cnt = 0; x_iv = 0;
        end else begin
            if (wb_valid && int'(wb_warp) < NW) m_pend[wb_warp][wb_reg] = 0;
            x_iv = 0;
            if (m_cnt == 0) begin
                for (int i = 0; i < NW; i++) begin
                    int w;
                    w = (m_ptr + i) % NW;
                    if (!x_iv && m_ok(w)) begin
                        x_iv = 1; x_warp = w; x_wen = e_wen[w]; x_dst = e_dst[w];
                        x_sa = e_sa[w]; x_sb = e_sb[w]; x_lat = e_lat[w];
                    end
                end
                if (x_iv) begin
                    if (x_wen) m_pend[x_warp][x_dst] = 1;
                    m_ptr = (x_warp + 1) % NW;
                    m_cnt = IC - 1;
                end
            end else begin
                m_cnt--;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, sampled at the falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk(issue_valid == x_iv, "R2 R6 R7 issue_valid", issue_valid, x_iv);
            if (x_iv && issue_valid) begin
                chk(int'(issue_warp) == x_warp, "R6 issue_warp", issue_warp, x_warp);
                chk(issue_wen == x_wen && int'(issue_dst) == x_dst &&
                    int'(issue_src_a) == x_sa && int'(issue_src_b) == x_sb &&
                    int'(issue_lat) == x_lat, "R8 issue fields",
                    {issue_wen, issue_dst, issue_src_a, issue_src_b, issue_lat},
                    {x_wen, x_dst[RW-1:0], x_sa[RW-1:0], x_sb[RW-1:0], x_lat[1:0]});
            end
            chk(dispatch_busy == (m_cnt != 0), "R5 dispatch_busy", dispatch_busy, m_cnt != 0);
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic clear_all();
        for (int w = 0; w < NW; w++) begin
            e_valid[w] = 0; e_wen[w] = 0; e_dst[w] = 0;
            e_sa[w] = 0; e_sb[w] = 0; e_lat[w] = 0;
        end
        wb_valid = 0; wb_warp = 0; wb_reg = 0;
    endtask

    task automatic put(int w, bit wen, int d, int a, int b, int lat);
        e_valid[w] = 1; e_wen[w] = wen; e_dst[w] = RW'(d);
        e_sa[w] = RW'(a); e_sb[w] = RW'(b); e_lat[w] = 2'(lat);
    endtask

    task automatic wait_free();
        while (dispatch_busy) step();
    endtask

    bit finished = 0;

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        clear_all();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        model_on = 1;
        step();
        // R1: reset state
        chk(issue_valid == 0 && dispatch_busy == 0, "R1 reset outputs",
            {issue_valid, dispatch_busy}, 0);

        // R3: issue marks destination pending
        put(2, 1, 5, 0, 1, 1);
        step();
        chk(issue_valid && issue_warp == 2, "R3 first issue of warp 2", issue_warp, 2);
        e_valid[2] = 0;
        // R10: write-after-write stall on r5
        put(2, 1, 5, 2, 3, 0);
        seen = 0;
        repeat (10) begin step(); if (issue_valid) seen++; end
        chk(seen == 0, "R10 WAW entry stays stalled", seen, 0);
        // R4: same-cycle writeback bypass lets it issue
        wb_valid = 1; wb_warp = 2; wb_reg = 5;
        step();
        wb_valid = 0;
        chk(issue_valid && issue_warp == 2 && issue_dst == 5, "R4 bypass issue",
            issue_valid, 1);
        e_valid[2] = 0;
        step(); wait_free();

        // R9: issue and writeback on the same register in one cycle
        put(2, 1, 5, 0, 1, 2);
        wb_valid = 1; wb_warp = 2; wb_reg = 5;
        step();
        wb_valid = 0;
        chk(issue_valid && issue_warp == 2, "R9 racing issue happens", issue_valid, 1);
        e_valid[2] = 0;
        put(2, 0, 6, 5, 0, 0);
        seen = 0;
        repeat (8) begin step(); if (issue_valid) seen++; end
        chk(seen == 0, "R9 set wins over same-cycle clear", seen, 0);
        // R7: stalled warp 2 does not block ready warp 4
        put(4, 0, 0, 1, 2, 3);
        step();
        chk(issue_valid && issue_warp == 4, "R7 other warp issues", issue_warp, 4);
        e_valid[4] = 0;
        step(); wait_free();
        // R4: out-of-range writeback warp has no effect
        wb_valid = 1; wb_warp = WW'(NW); wb_reg = 5;
        step(); wb_valid = 0;
        repeat (3) step();
        chk(issue_valid == 0, "R4 out-of-range writeback ignored", issue_valid, 0);
        wb_valid = 1; wb_warp = 2; wb_reg = 5;
        step(); wb_valid = 0;
        chk(issue_valid && issue_warp == 2, "R4 release after writeback", issue_warp, 2);
        e_valid[2] = 0;
        step(); wait_free();

        // R6: all warps ready, pointer now after warp 2 -> 3,4,5,0,1
        for (int w = 0; w < NW; w++) put(w, 0, 0, 7, 7, w % 4);
        for (int k = 0; k < NW; k++) begin
            int exp_w;
            exp_w = (3 + k) % NW;
            step();
            chk(issue_valid && int'(issue_warp) == exp_w, "R6 rotation order",
                issue_warp, exp_w);
            e_valid[issue_warp] = 0;
            repeat (IC - 1) step();
        end

        // Random traffic compared against the model each cycle
        clear_all();
        for (int c = 0; c < 4000; c++) begin
            step();
            if (issue_valid) e_valid[issue_warp] = 0;
            for (int w = 0; w < NW; w++)
                if (!e_valid[w] && $urandom_range(0, 3) == 0)
                    put(w, 1'($urandom_range(0, 1)), $urandom_range(0, NR - 1),
                        $urandom_range(0, NR - 1), $urandom_range(0, NR - 1),
                        $urandom_range(0, 3));
            wb_valid = 0;
            if ($urandom_range(0, 2) != 0) begin
                for (int t = 0; t < 6; t++) begin
                    int w, r;
                    w = $urandom_range(0, NW - 1);
                    r = $urandom_range(0, NR - 1);
                    if (!wb_valid && (m_pend[w][r] || t == 5)) begin
                        wb_valid = 1; wb_warp = WW'(w); wb_reg = RW'(r);
                    end
                end
            end
        end
        step();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule